// File: doc/BRIEF.md
# Ping-Pong Display Line Buffer

This block sits between a burst-capable frame memory reader and a display timing generator. It holds two line-sized RAMs. While one RAM streams pixels out during an active display line, the other is loaded with a later line. After each active line the two RAMs trade roles. At the start of each frame the block prefetches the first two lines of the picture during vertical blanking. It then refills each RAM with the line two ahead as soon as the RAM has been shown.

Reads from memory are requested one burst at a time. Each request names a line, a starting pixel offset and a length. The length is the configured burst size, or the pixels still missing from the line if fewer remain. Pixels of a line land at RAM addresses counting up from 0. A pair counter advances each time the second RAM finishes an active line. When it reaches half the configured line count, the frame is complete. The block then stops requesting until the next frame start pulse. A line that is not fully loaded when it must be shown yields zero pixels, flagged as underrun.

Top module: `line_pingpong_buf`

## Requirements
- R1: After reset, and before the first `frame_start`, no request is raised, `pix_valid` and `underrun` are 0, and `frame_done` is 0.
- R2: After `frame_start`, requests name lines 0, 1, 2, … in order. Within a line, offsets start at 0 and advance by the previous length. Each length is min(BURST, `cfg_line_pix` − offset), so the offset plus the length never exceeds the line size.
- R3: Lines 0 and 1 are both loaded before any active line without intervening display. No request for line k+2 appears before the active period of line k has ended.
- R4: `pix_valid` equals `de` delayed by one clock. While it is high, `pix_data` is pixel p of line n, where n counts the active periods since `frame_start` and p counts the clocks since the current active period began. Lines alternate between the two RAMs.
- R5: Memory words fill a line in arrival order, from offset 0 upward. The k-th word delivered for a request at offset o is shown as pixel o+k.
- R6: A pixel read while its line is not yet completely loaded appears as 0 with `underrun` high in the same cycle. Pixels read after the line completes carry correct data.
- R7: `frame_done` rises one clock after the end of the active period that completes `cfg_lines`/2 RAM pairs. While it is high, no request is raised. `frame_start` clears it.
- R8: Neither RAM is written and read in the same clock.
- R9: A raised request keeps its line, offset and length unchanged until `req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-clock pulse at the start of vertical blanking |
| de | input | 1 | Display data enable, high for exactly one line of pixels |
| cfg_line_pix | input | AW+1 | Pixels per line (1 to DEPTH) |
| cfg_lines | input | LINE_W | Active lines per frame (even) |
| req_valid | output | 1 | Burst read request pending |
| req_ready | input | 1 | Memory side accepts the pending request |
| req_line | output | LINE_W | Line number of the request |
| req_offset | output | AW+1 | First pixel offset of the request |
| req_len | output | LEN_W | Words in the burst |
| mem_valid | input | 1 | A burst word is present |
| mem_data | input | DATA_W | Burst word |
| pix_valid | output | 1 | Delayed data enable |
| pix_data | output | DATA_W | Pixel out |
| underrun | output | 1 | Current pixel was not yet loaded and is forced to 0 |
| frame_done | output | 1 | All lines of the frame have been shown |

## Verification
The properties rely on the following conditions:
- `de` stays high for exactly `cfg_line_pix` clocks per line.
- `frame_start` arrives only while `de` is low and no burst is in flight.
- The configuration is stable during a frame.
- The memory side returns exactly `req_len` words after each acceptance.
- Every line finishes loading before its own active period ends.

The bench's memory responder produces each burst from the request it accepted, so the word count always matches. The bench changes the configuration only between frames. It spaces the active lines so that each refill completes in time. Underrun is provoked by a single deliberate case: the first active line starts while line 0 is still partly loaded.

// File: rtl/lb_pkg.sv
package lb_pkg;
   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_REQ  = 2'd1,
      FILL_DATA = 2'd2
   } fill_st_t;
endpackage

// File: rtl/lb_ram.sv
module lb_ram #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2048,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] mem [DEPTH];

   // one access per clock is guaranteed by the caller (write only when empty, read only when full)
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) q <= mem[raddr];
   end
endmodule

// File: rtl/lb_fill.sv
module lb_fill
   import lb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2048,
   parameter int BURST  = 256,
   parameter int LINE_W = 11,
   localparam int AW    = $clog2(DEPTH),
   localparam int LEN_W = $clog2(BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [AW:0]       cfg_line_pix,
   input  logic [LINE_W-1:0] cfg_lines,
   input  logic              done,
   input  logic [1:0]        full,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [LINE_W-1:0] req_line,
   output logic [AW:0]       req_offset,
   output logic [LEN_W-1:0]  req_len,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data,
   output logic [1:0]        wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              line_loaded,
   output logic              loaded_sel
);
   localparam logic [AW:0]      BURST_A = (AW+1)'(BURST);
   localparam logic [LEN_W-1:0] BURST_L = LEN_W'(BURST);

   fill_st_t          st;
   logic              tgt;
   logic              active;
   logic [LINE_W:0]   line_cnt;
   logic [AW:0]       wcnt;
   logic [LEN_W-1:0]  left;
   logic [AW:0]       remain;
   logic              last_word;

   assign remain    = cfg_line_pix - wcnt;
   assign req_len   = (remain > BURST_A) ? BURST_L : remain[LEN_W-1:0];
   assign req_valid = (st == FILL_REQ);
   assign req_line  = line_cnt[LINE_W-1:0];
   assign req_offset = wcnt;
   assign wr_addr   = wcnt[AW-1:0];
   assign wr_data   = mem_data;
   assign last_word = (st == FILL_DATA) && mem_valid && (left == LEN_W'(1));
   assign line_loaded = last_word && ((wcnt + 1'b1) == cfg_line_pix);
   assign loaded_sel  = tgt;

   always_comb begin
      for (int i = 0; i < 2; i++)
         wr_en[i] = (st == FILL_DATA) && mem_valid && (tgt == i[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || frame_start) begin
         st       <= FILL_IDLE;
         tgt      <= 1'b0;
         active   <= frame_start && rst_n;
         line_cnt <= '0;
         wcnt     <= '0;
         left     <= '0;
      end else begin
         unique case (st)
            FILL_IDLE: begin
               if (active && !done && (line_cnt < {1'b0, cfg_lines}) &&
                   !full[tgt] && (cfg_line_pix != '0))
                  st <= FILL_REQ;
            end
            FILL_REQ: begin
               if (req_ready) begin
                  left <= req_len;
                  st   <= FILL_DATA;
               end
            end
            FILL_DATA: begin
               if (mem_valid) begin
                  wcnt <= wcnt + 1'b1;
                  left <= left - 1'b1;
                  if (line_loaded) begin
                     wcnt     <= '0;
                     line_cnt <= line_cnt + 1'b1;
                     tgt      <= ~tgt;
                     st       <= FILL_IDLE;
                  end else if (last_word) begin
                     st <= FILL_REQ;
                  end
               end
            end
            default: st <= FILL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lb_read.sv
module lb_read #(
   parameter int DEPTH  = 2048,
   parameter int LINE_W = 11,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              de,
   input  logic [LINE_W-1:0] cfg_lines,
   input  logic [1:0]        full,
   output logic [1:0]        rd_en,
   output logic [AW-1:0]     rd_addr,
   output logic              sel_q,
   output logic              zero_q,
   output logic              de_q,
   output logic              line_done,
   output logic              done_sel,
   output logic              frame_done
);
   logic              rd_sel;
   logic [AW-1:0]     rcnt;
   logic [LINE_W-1:0] pair;
   logic [LINE_W-1:0] half;

   assign half      = cfg_lines >> 1;
   assign rd_addr   = rcnt;
   assign line_done = de_q && !de;
   assign done_sel  = rd_sel;

   always_comb begin
      for (int i = 0; i < 2; i++)
         rd_en[i] = de && full[rd_sel] && (rd_sel == i[0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || frame_start) begin
         rd_sel     <= 1'b0;
         rcnt       <= '0;
         pair       <= '0;
         frame_done <= 1'b0;
         de_q       <= 1'b0;
         sel_q      <= 1'b0;
         zero_q     <= 1'b0;
      end else begin
         de_q   <= de;
         sel_q  <= rd_sel;
         zero_q <= de && !full[rd_sel];
         if (de) rcnt <= rcnt + 1'b1;
         if (line_done) begin
            rcnt   <= '0;
            rd_sel <= ~rd_sel;
            if (rd_sel) begin
               if ((pair + 1'b1) == half) begin
                  pair       <= '0;
                  frame_done <= 1'b1;
               end else begin
                  pair <= pair + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/line_pingpong_buf.sv
module line_pingpong_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 2048,
   parameter int BURST  = 256,
   parameter int LINE_W = 11,
   localparam int AW    = $clog2(DEPTH),
   localparam int LEN_W = $clog2(BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              de,
   input  logic [AW:0]       cfg_line_pix,
   input  logic [LINE_W-1:0] cfg_lines,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [LINE_W-1:0] req_line,
   output logic [AW:0]       req_offset,
   output logic [LEN_W-1:0]  req_len,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data,
   output logic              pix_valid,
   output logic [DATA_W-1:0] pix_data,
   output logic              underrun,
   output logic              frame_done
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BURST < 1 || BURST > DEPTH) begin : g_bad_burst
      $error("BURST must lie between 1 and DEPTH");
   end
   if (LINE_W < 2) begin : g_bad_line_w
      $error("LINE_W must be at least 2");
   end

   logic [1:0]        full;
   logic [1:0]        wr_en;
   logic [1:0]        rd_en;
   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] bank_q [2];
   logic              line_loaded, loaded_sel;
   logic              line_done, done_sel;
   logic              sel_q, zero_q, de_q;

   lb_fill #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST(BURST), .LINE_W(LINE_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .cfg_line_pix(cfg_line_pix), .cfg_lines(cfg_lines),
      .done(frame_done), .full(full),
      .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
      .req_offset(req_offset), .req_len(req_len),
      .mem_valid(mem_valid), .mem_data(mem_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .line_loaded(line_loaded), .loaded_sel(loaded_sel)
   );

   lb_read #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_read (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .de(de),
      .cfg_lines(cfg_lines), .full(full),
      .rd_en(rd_en), .rd_addr(rd_addr), .sel_q(sel_q), .zero_q(zero_q),
      .de_q(de_q), .line_done(line_done), .done_sel(done_sel),
      .frame_done(frame_done)
   );

   for (genvar i = 0; i < 2; i++) begin : g_bank
      lb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
         .clk(clk), .we(wr_en[i]), .waddr(wr_addr), .wdata(wr_data),
         .re(rd_en[i]), .raddr(rd_addr), .q(bank_q[i])
      );
   end

   // a bank becomes full when its last word lands and empty when its line has been shown
   always_ff @(posedge clk) begin
      if (!rst_n || frame_start) begin
         full <= '0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            if (line_loaded && (loaded_sel == i[0]))
               full[i] <= 1'b1;
            else if (line_done && (done_sel == i[0]))
               full[i] <= 1'b0;
         end
      end
   end

   assign pix_valid = de_q;
   assign underrun  = zero_q;
   assign pix_data  = (de_q && !zero_q) ? bank_q[sel_q] : '0;
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
   parameter int DATA_W = 16,
   parameter int AW     = 11,
   parameter int BURST  = 256,
   parameter int LINE_W = 11,
   parameter int LEN_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              de,
   input logic [AW:0]       cfg_line_pix,
   input logic              req_valid,
   input logic              req_ready,
   input logic [LINE_W-1:0] req_line,
   input logic [AW:0]       req_offset,
   input logic [LEN_W-1:0]  req_len,
   input logic              pix_valid,
   input logic [DATA_W-1:0] pix_data,
   input logic              underrun,
   input logic              frame_done,
   input logic [1:0]        wr_en,
   input logic [1:0]        rd_en
);
   // R8: single-port use of each bank
   p_single_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en & rd_en) == 2'b00);

   // R9: pending request held until accepted
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !frame_start) |=>
         (req_valid && $stable(req_line) && $stable(req_offset) && $stable(req_len)));

   // R2: burst length bounded by burst size and rest of line
   p_req_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != '0) && (int'(req_len) <= BURST) &&
                    ((int'(req_offset) + int'(req_len)) <= int'(cfg_line_pix)));

   // R4: output valid is data enable delayed by one clock
   p_pix_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> (pix_valid == $past(de)));

   // R6: an underrun pixel is a valid zero
   p_under_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> (pix_valid && (pix_data == '0)));

   // R7: no request once the frame is complete
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !req_valid);

   // R7: frame_start clears the completion flag
   p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_done);
endmodule

bind line_pingpong_buf lb_checker #(
   .DATA_W(DATA_W), .AW(AW), .BURST(BURST), .LINE_W(LINE_W), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .de(de),
   .cfg_line_pix(cfg_line_pix), .req_valid(req_valid), .req_ready(req_ready),
   .req_line(req_line), .req_offset(req_offset), .req_len(req_len),
   .pix_valid(pix_valid), .pix_data(pix_data), .underrun(underrun),
   .frame_done(frame_done), .wr_en(wr_en), .rd_en(rd_en)
);

// File: tb/tb_line_pingpong_buf.sv
module tb_line_pingpong_buf;
   localparam int DW = 16, DEPTH = 64, BURST = 8, LW = 6;
   localparam int AW = $clog2(DEPTH);
   localparam int LEN_W = $clog2(BURST + 1);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, frame_start, de, req_ready, mem_valid;
   logic [AW:0] cfg_line_pix;
   logic [LW-1:0] cfg_lines;
   logic [DW-1:0] mem_data;
   logic req_valid, pix_valid, underrun, frame_done;
   logic [LW-1:0] req_line;
   logic [AW:0] req_offset;
   logic [LEN_W-1:0] req_len;
   logic [DW-1:0] pix_data;

   line_pingpong_buf #(.DATA_W(DW), .DEPTH(DEPTH), .BURST(BURST), .LINE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .de(de),
      .cfg_line_pix(cfg_line_pix), .cfg_lines(cfg_lines),
      .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
      .req_offset(req_offset), .req_len(req_len),
      .mem_valid(mem_valid), .mem_data(mem_data),
      .pix_valid(pix_valid), .pix_data(pix_data), .underrun(underrun),
      .frame_done(frame_done)
   );

   int n_cmp = 0, n_bad = 0;
   int frame_id = 0, mem_lat = 2;
   int sent_line = -1, sent_off = -1;
   int lines_read = 0;
   int exp_req_line = 0, exp_req_off = 0;
   int mem_cur_line = 0;
   int n_under = 0;
   logic mem_last = 1'b0;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;

   function automatic logic [DW-1:0] word(int f, int l, int o);
      return {f[3:0], l[5:0], o[5:0]};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: per-line completion times and pixel positions
   int  m_line, m_pix;
   bit  m_prev_de, m_done;
   bit  comp [64];
   logic exp_valid, exp_under;
   logic [DW-1:0] exp_data;

   always @(posedge clk) begin
      if (!rst_n || frame_start) begin
         m_line = 0; m_pix = 0; m_prev_de = 0; m_done = 0;
         foreach (comp[i]) comp[i] = 0;
         exp_valid = 0; exp_under = 0; exp_data = '0;
      end else begin
         exp_valid = de; exp_under = 0; exp_data = '0;
         if (de) begin
            if (comp[m_line]) exp_data = word(frame_id, m_line, m_pix);
            else begin exp_under = 1; n_under++; end
            m_pix++;
         end
         if (m_prev_de && !de) begin
            m_line++; m_pix = 0;
            if (m_line == int'(cfg_lines)) m_done = 1;
         end
         m_prev_de = de;
         if (mem_valid && mem_last) comp[mem_cur_line] = 1;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !finished) begin
         check("R4 pix_valid", 32'(pix_valid), 32'(exp_valid));
         check("R4/R5/R6 pix_data", 32'(pix_data), 32'(exp_data));
         check("R6 underrun", 32'(underrun), 32'(exp_under));
         check("R7 frame_done", 32'(frame_done), 32'(m_done));
      end
   end

   // memory responder
   int ql, qo, qn, ql_exp_len;
   initial begin
      req_ready = 0; mem_valid = 0; mem_data = '0;
      forever begin
         @(negedge clk);
         if (rst_n && req_valid && !finished) begin
            ql = int'(req_line); qo = int'(req_offset); qn = int'(req_len);
            ql_exp_len = (int'(cfg_line_pix) - qo > BURST) ? BURST : int'(cfg_line_pix) - qo;
            check("R2 req_line", 32'(ql), 32'(exp_req_line));
            check("R2 req_offset", 32'(qo), 32'(exp_req_off));
            check("R2 req_len", 32'(qn), 32'(ql_exp_len));
            if (qo == 0 && ql >= 2)
               check("R3 refill after line k shown", 32'(lines_read >= ql - 1), 32'd1);
            check("R7 no request after frame end", 32'(m_done), 32'd0);
            repeat (mem_lat) begin
               @(negedge clk);
               check("R9 request held", {req_valid, 9'(req_line), 7'(req_offset), 4'(req_len)},
                     {1'b1, 9'(ql), 7'(qo), 4'(qn)});
            end
            req_ready = 1;
            @(negedge clk);
            req_ready = 0;
            for (int k = 0; k < qn; k++) begin
               mem_valid = 1;
               mem_data = word(frame_id, ql, qo + k);
               mem_last = (qo + k == int'(cfg_line_pix) - 1);
               mem_cur_line = ql;
               sent_line = ql; sent_off = qo + k;
               @(negedge clk);
            end
            mem_valid = 0; mem_last = 0;
            if (qo + qn == int'(cfg_line_pix)) begin
               exp_req_line = ql + 1; exp_req_off = 0;
            end else begin
               exp_req_off = qo + qn;
            end
         end
      end
   end

   task automatic run_frame(int fid, int m, int y, int lat, int blank, int gap, int wait_off);
      cfg_line_pix = (AW+1)'(m);
      cfg_lines = LW'(y);
      frame_id = fid; mem_lat = lat;
      exp_req_line = 0; exp_req_off = 0; lines_read = 0; sent_line = -1; sent_off = -1;
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
      if (wait_off < 0) begin
         repeat (blank) @(negedge clk);
         // R3: exactly two lines prefetched, the third not yet asked for
         check("R3 two lines prefetched", 32'(exp_req_line), 32'd2);
         check("R3 third line waits", 32'(req_valid), 32'd0);
      end else begin
         while (!(sent_line == 0 && sent_off >= wait_off)) @(negedge clk);
      end
      for (int ln = 0; ln < y; ln++) begin
         de = 1;
         repeat (m) @(negedge clk);
         de = 0;
         lines_read++;
         repeat (gap) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      check("R7 frame_done after last pair", 32'(frame_done), 32'd1);
      check("R7 quiet after frame", 32'(req_valid), 32'd0);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 0; frame_start = 0; de = 0;
      cfg_line_pix = (AW+1)'(20); cfg_lines = LW'(4);
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cmp_on = 1;
      // R1: idle until the first frame start
      for (int i = 0; i < 10; i++) begin
         check("R1 no request before frame", 32'(req_valid), 32'd0);
         check("R1 no output before frame", 32'(pix_valid), 32'd0);
         @(negedge clk);
      end
      check("R1 frame_done low", 32'(frame_done), 32'd0);
      // frame 1: ragged last burst, generous blanking
      run_frame(1, 20, 4, 2, 150, 40, -1);
      // frame 2: exact bursts, slow memory, display starts while line 0 loads
      run_frame(2, 16, 6, 12, 0, 60, 10);
      check("R6 underrun observed", 32'(n_under > 0), 32'd1);
      // frame 3: back to normal timing after a completed frame
      run_frame(3, 24, 4, 1, 150, 40, -1);
      finish_run();
   end
endmodule